// File: doc/BRIEF.md
# Serial CORDIC Eighth-Rate Quadrature Downconverter

The block moves a real audio stream, sampled at 12 kSPS, down by one eighth of its sample rate (1500 Hz). The result is a complex zero-IF pair (I, Q). Every accepted sample is rotated clockwise by an angle that grows by 45° from one sample to the next. The rotation needs no multiplier and no sine table. A five-step shift-and-add rotator turns the vector by ±22.5°. A quadrant stage then swaps and negates the two components by whole multiples of 90°. Together they reach every angle of the form −(22.5° + 45°·n). The fixed −22.5° offset is a constant phase of the local oscillator.

The five micro-rotations use the shift amounts 1, 4, 7, 10 and 12. They are computed one bit per clock, least significant bit first, so each stage takes one clock per data bit. At the default 16-bit width, a result appears 80 clocks after its sample was accepted. The rotator gain of about 1.12 is not corrected. Every stage saturates instead of wrapping. A three-bit phase index decides the rotation direction and the quadrant. It steps once per converted sample and repeats every eight samples.

Top module: `sdc_downconv`

## Requirements
- R1: While reset is held and right after it is released, `cv_valid` is 0 and `cv_i` and `cv_q` are 0, and the phase index is 0, so the first sample is converted as phase 0.
- R2: An asserted `au_valid` is accepted at a rising edge when no conversion is in progress. `cv_valid` then goes high for exactly one cycle, at the 80th rising edge after the accepting edge (5 stages × 16 bits). It is low at the 79th edge.
- R3: The sample is loaded as x = sample, y = 0. Stage k (k = 0..4) uses the shift s = 1, 4, 7, 10, 12 and the base sign b = +1, −1, −1, −1, +1. It computes x' = sat(x − d·(y >>> s)) and y' = sat(y + d·(x >>> s)) with d = b·r. The shift is arithmetic, and sat clamps to [−32768, 32767].
- R4: The rotation sign is r = −1 for an even phase index (nominal −22.5°) and r = +1 for an odd phase index.
- R5: The quadrant is q = ((p + 1) >> 1) mod 4, applied after the last stage. It maps (x, y) to (I, Q) as follows: q=0 gives (x, y), q=1 gives (y, −x), q=2 gives (−x, −y), q=3 gives (−y, x). Negation saturates, so −(−32768) gives 32767.
- R6: The phase index p advances by one after each completed conversion and wraps modulo 8, so the rotation pattern repeats every eight samples.
- R7: An `au_valid` that arrives while a conversion is in progress is ignored. This holds for any edge from the one after acceptance up to and including the edge that raises `cv_valid`. Such a strobe changes neither the current result nor the phase index.
- R8: `cv_i` and `cv_q` hold their values in every cycle in which `cv_valid` is low.
- R9: A zero input sample gives I = Q = 0 at every phase, with no residual carrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| au_valid | input | 1 | Sample strobe |
| au_data | input | W | Signed audio sample |
| cv_i | output | W | In-phase result, signed |
| cv_q | output | W | Quadrature result, signed |
| cv_valid | output | 1 | One-cycle result strobe |

## Verification
The assertions check on every cycle that:
- the result strobe comes exactly 80 edges after an accepted sample, and is a single-cycle pulse;
- the outputs stay frozen between strobes;
- a zero sample yields a zero pair.

The checker keeps its own model of the busy window, which also covers the rejection of strobes while a conversion is in progress.

Only the bench scenarios can show the following:
- the numeric result of each stage, with its signed shifts, saturation and direction;
- the quadrant mapping, including saturating negation;
- the eight-sample phase cycle;
- that an ignored strobe leaves the phase sequence untouched.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    // number of micro-rotation stages in the fixed 22.5 degree decomposition
    localparam int unsigned NST = 5;

    // right-shift amount used by each stage
    function automatic int unsigned stage_shift(input int unsigned k);
        case (k)
            0:       return 1;
            1:       return 4;
            2:       return 7;
            3:       return 10;
            default: return 12;
        endcase
    endfunction

    // 1 when the stage turns the vector counter-clockwise for a +22.5 degree rotation
    function automatic logic stage_pos(input int unsigned k);
        return (k == 0) || (k == 4);
    endfunction

endpackage

// File: rtl/sdc_bit_cell.sv
// One bit slice of a serial adder/subtractor with overflow detection at the top bit.
module sdc_bit_cell (
    input  logic a,
    input  logic b,
    input  logic sub,
    input  logic first,
    input  logic c_prev,
    output logic s,
    output logic c_out,
    output logic ovf
);
    logic b_eff;
    logic c_in;

    always_comb begin
        b_eff = b ^ sub;
        c_in  = first ? sub : c_prev;
        s     = a ^ b_eff ^ c_in;
        c_out = (a & b_eff) | (a & c_in) | (b_eff & c_in);
        ovf   = c_in ^ c_out;
    end
endmodule

// File: rtl/sdc_phase_seq.sv
// Eight-step phase index: picks the rotation sign and the quadrant.
module sdc_phase_seq #(
    parameter int unsigned PW = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       advance,
    output logic       rot_pos,
    output logic [1:0] quad
);
    typedef struct packed {
        logic [PW-1:0] phase;
    } seq_t;

    seq_t st_q, st_d;
    logic [PW:0] p_inc;

    always_comb begin
        st_d = st_q;
        if (advance) st_d.phase = st_q.phase + 1'b1;
        p_inc   = {1'b0, st_q.phase} + 1'b1;
        rot_pos = st_q.phase[0];
        quad    = p_inc[2:1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sdc_quad_map.sv
// Whole-quadrant rotation by -90 degree steps with saturating negation.
module sdc_quad_map #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [1:0]   quad,
    output logic [W-1:0] qi,
    output logic [W-1:0] qq
);
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] nx, ny;

    always_comb begin
        nx = (x == MINV) ? MAXV : (~x + 1'b1);
        ny = (y == MINV) ? MAXV : (~y + 1'b1);
        case (quad)
            2'd0:    begin qi = x;  qq = y;  end
            2'd1:    begin qi = y;  qq = nx; end
            2'd2:    begin qi = nx; qq = ny; end
            default: begin qi = ny; qq = x;  end
        endcase
    end
endmodule

// File: rtl/sdc_downconv.sv
// Bit-serial fixed-angle rotator followed by a quadrant stage.
module sdc_downconv #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         au_valid,
    input  logic [W-1:0] au_data,
    output logic [W-1:0] cv_i,
    output logic [W-1:0] cv_q,
    output logic         cv_valid
);
    import sdc_pkg::*;

    localparam int unsigned BW    = $clog2(W);
    localparam int unsigned IW    = BW + 1;
    localparam int unsigned SW    = $clog2(NST);
    localparam int unsigned NLANE = 2;

    typedef struct packed {
        logic          busy;
        logic [SW-1:0] stage;
        logic [BW-1:0] bitn;
        logic [W-1:0]  x;
        logic [W-1:0]  y;
        logic [W-1:0]  nx;
        logic [W-1:0]  ny;
        logic [1:0]    carry;
        logic [W-1:0]  oi;
        logic [W-1:0]  oq;
        logic          ov;
    } core_t;

    core_t r_q, r_d;

    logic [NLANE-1:0] la, lb, lsub, ls, lco, lov;
    logic [IW-1:0]    idx;
    logic             d_pos;
    logic             first_bit, last_bit, last_stage, finish;
    logic             rot_pos;
    logic [1:0]       quad;
    logic [W-1:0]     x_fin, y_fin, m_i, m_q;

    // operand selection for the two serial lanes
    always_comb begin
        idx = {1'b0, r_q.bitn} + IW'(stage_shift(int'(r_q.stage)));
        if (idx > IW'(W - 1)) idx = IW'(W - 1);
        d_pos      = stage_pos(int'(r_q.stage)) ~^ rot_pos;
        first_bit  = (r_q.bitn == '0);
        last_bit   = (r_q.bitn == BW'(W - 1));
        last_stage = (r_q.stage == SW'(NST - 1));
        finish     = r_q.busy && last_bit && last_stage;
        la[0]   = r_q.x[r_q.bitn];
        lb[0]   = r_q.y[idx[BW-1:0]];
        lsub[0] = d_pos;
        la[1]   = r_q.y[r_q.bitn];
        lb[1]   = r_q.x[idx[BW-1:0]];
        lsub[1] = ~d_pos;
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        sdc_bit_cell u_cell (
            .a      (la[g]),
            .b      (lb[g]),
            .sub    (lsub[g]),
            .first  (first_bit),
            .c_prev (r_q.carry[g]),
            .s      (ls[g]),
            .c_out  (lco[g]),
            .ovf    (lov[g])
        );
    end

    // stage result with saturation on overflow of the top bit
    always_comb begin
        if (lov[0]) x_fin = la[0] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else        x_fin = {ls[0], r_q.nx[W-2:0]};
        if (lov[1]) y_fin = la[1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else        y_fin = {ls[1], r_q.ny[W-2:0]};
    end

    sdc_phase_seq #(.PW(3)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (finish),
        .rot_pos (rot_pos),
        .quad    (quad)
    );

    sdc_quad_map #(.W(W)) u_map (
        .x    (x_fin),
        .y    (y_fin),
        .quad (quad),
        .qi   (m_i),
        .qq   (m_q)
    );

    // next-state computation
    always_comb begin
        r_d    = r_q;
        r_d.ov = 1'b0;
        if (!r_q.busy) begin
            if (au_valid) begin
                r_d.busy  = 1'b1;
                r_d.stage = '0;
                r_d.bitn  = '0;
                r_d.x     = au_data;
                r_d.y     = '0;
            end
        end else begin
            r_d.nx[r_q.bitn] = ls[0];
            r_d.ny[r_q.bitn] = ls[1];
            r_d.carry        = lco;
            r_d.bitn         = r_q.bitn + 1'b1;
            if (last_bit) begin
                r_d.bitn  = '0;
                r_d.x     = x_fin;
                r_d.y     = y_fin;
                r_d.stage = r_q.stage + 1'b1;
                if (last_stage) begin
                    r_d.busy  = 1'b0;
                    r_d.stage = '0;
                    r_d.oi    = m_i;
                    r_d.oq    = m_q;
                    r_d.ov    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cv_i     = r_q.oi;
    assign cv_q     = r_q.oq;
    assign cv_valid = r_q.ov;
endmodule

// File: rtl/sdc_downconv_chk.sv
// Protocol and output checker, bound to the top module.
module sdc_downconv_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         au_valid,
    input logic [W-1:0] au_data,
    input logic [W-1:0] cv_i,
    input logic [W-1:0] cv_q,
    input logic         cv_valid
);
    localparam int unsigned LAT = sdc_pkg::NST * W;
    localparam int unsigned CW  = $clog2(LAT + 1);

    logic          busy_c;
    logic [CW-1:0] cnt_c;
    logic          done_exp;
    logic [W-1:0]  last_smp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_c   <= 1'b0;
            cnt_c    <= '0;
            done_exp <= 1'b0;
            last_smp <= '0;
        end else begin
            done_exp <= busy_c && (cnt_c == CW'(LAT - 1));
            if (!busy_c) begin
                if (au_valid) begin
                    busy_c   <= 1'b1;
                    cnt_c    <= '0;
                    last_smp <= au_data;
                end
            end else begin
                cnt_c <= cnt_c + 1'b1;
                if (cnt_c == CW'(LAT - 1)) busy_c <= 1'b0;
            end
        end
    end

    // R2: result strobe exactly LAT edges after acceptance, R7: strobes in the busy window start nothing
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        cv_valid == done_exp);

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cv_valid |=> !cv_valid);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cv_valid |-> ($stable(cv_i) && $stable(cv_q)));

    a_r9_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_valid && last_smp == '0) |-> (cv_i == '0 && cv_q == '0));
endmodule

bind sdc_downconv sdc_downconv_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .au_valid (au_valid),
    .au_data  (au_data),
    .cv_i     (cv_i),
    .cv_q     (cv_q),
    .cv_valid (cv_valid)
);

// File: tb/sdc_downconv_test.sv
module sdc_downconv_test;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int LAT        = 80;
    localparam int WDOG       = 30000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         au_valid = 1'b0;
    logic [W-1:0] au_data = '0;
    logic [W-1:0] cv_i, cv_q;
    logic         cv_valid;

    int total = 0;
    int bad   = 0;
    int ph    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdc_downconv #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .au_valid(au_valid), .au_data(au_data),
        .cv_i(cv_i), .cv_q(cv_q), .cv_valid(cv_valid)
    );

    function automatic int sat16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // reference from R3..R5: returns {I, Q}
    function automatic logic [31:0] ref_conv(input logic signed [15:0] s, input int p);
        int sh[5] = '{1, 4, 7, 10, 12};
        int bs[5] = '{1, -1, -1, -1, 1};
        int x, y, nx, ny, r, d, q, oi, oq;
        x = s; y = 0;
        r = (p % 2 == 1) ? 1 : -1;
        for (int k = 0; k < 5; k++) begin
            d  = bs[k] * r;
            nx = sat16(x - d * (y >>> sh[k]));
            ny = sat16(y + d * (x >>> sh[k]));
            x = nx; y = ny;
        end
        q = ((p + 1) / 2) % 4;
        case (q)
            0:       begin oi = x;             oq = y;             end
            1:       begin oi = y;             oq = sat16(-x);     end
            2:       begin oi = sat16(-x);     oq = sat16(-y);     end
            default: begin oi = sat16(-y);     oq = x;             end
        endcase
        return {oi[15:0], oq[15:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one conversion; optional ignored strobes mid-way and on the done edge (R7)
    task automatic run_sample(input logic signed [15:0] s, input bit poke_mid, input bit poke_end, input string req);
        logic [31:0] e;
        e = ref_conv(s, ph);
        @(negedge clk); au_valid = 1'b1; au_data = s;
        @(negedge clk); au_valid = 1'b0;
        for (int k = 1; k <= LAT; k++) begin
            au_valid = (poke_mid && k == 40) || (poke_end && k == LAT);
            if (au_valid) au_data = 16'h5A5A;
            @(negedge clk);
            if (k == LAT - 1) check(cv_valid == 1'b0, "R2", "strobe early", int'(cv_valid), 0);
        end
        au_valid = 1'b0;
        check(cv_valid == 1'b1, "R2", "strobe at 80", int'(cv_valid), 1);
        check(cv_i == e[31:16], req, $sformatf("I phase %0d in %0d", ph, s), int'($signed(cv_i)), int'($signed(e[31:16])));
        check(cv_q == e[15:0],  req, $sformatf("Q phase %0d in %0d", ph, s), int'($signed(cv_q)), int'($signed(e[15:0])));
        ph = (ph + 1) % 8;
        @(negedge clk);
        check(cv_valid == 1'b0, "R2", "single pulse", int'(cv_valid), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(cv_valid == 1'b0 && cv_i == '0 && cv_q == '0, "R1", "in reset", int'(cv_i), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cv_valid == 1'b0 && cv_i == '0 && cv_q == '0, "R1", "after reset", int'(cv_q), 0);
        ph = 0;
    endtask

    task automatic t_phase_sweep;   // R3 R4 R5 R6
        int vals[8] = '{1000, -2000, 12345, -321, 7, -30000, 20000, 4096};
        for (int n = 0; n < 8; n++) run_sample(16'(vals[n]), 1'b0, 1'b0, "R3/R4/R5");
        for (int n = 0; n < 8; n++) run_sample(16'(vals[7 - n]), 1'b0, 1'b0, "R6");
    endtask

    task automatic t_full_scale;    // R3 saturation, R5 saturating negation
        for (int n = 0; n < 8; n++) run_sample(16'sh7FFF, 1'b0, 1'b0, "R3");
        for (int n = 0; n < 8; n++) run_sample(16'sh8000, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_zero;          // R9
        for (int n = 0; n < 8; n++) run_sample(16'sh0000, 1'b0, 1'b0, "R9");
    endtask

    task automatic t_ignored;       // R7: result and phase unaffected
        run_sample(16'sh1234, 1'b1, 1'b0, "R7");
        run_sample(-16'sh0777, 1'b0, 1'b1, "R7");
        run_sample(16'sh0F00, 1'b0, 1'b0, "R7");
    endtask

    task automatic t_hold;          // R8
        logic [W-1:0] hi, hq;
        run_sample(-16'sh2222, 1'b0, 1'b0, "R8");
        hi = cv_i; hq = cv_q;
        repeat (20) @(negedge clk);
        check(cv_i == hi && cv_q == hq && !cv_valid, "R8", "outputs held", int'(cv_i), int'(hi));
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        t_reset();
        t_phase_sweep();
        t_full_scale();
        t_zero();
        t_ignored();
        t_hold();
        summary();
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=done", WDOG);
        summary();
        $finish;
    end
endmodule